// File: doc/BRIEF.md
# Home Directory Coherence Engine

This block is the home-node side of a directory-based coherence scheme for a multiprocessor in which memory is distributed across nodes. For every memory block that lives at this node it records a coherence state (no cached copy, read-shared copies, or one writable owner). It also records a presence vector with one bit per processor. Requesting caches send it read misses, write misses and data write-backs over an in-order request channel. The engine answers with point-to-point messages on a response channel. Any copy that has to be recalled or invalidated is contacted individually, and every miss ends with an explicit data reply to the requester.

Multi-step transactions are sequenced by a single engine. A write miss to a shared block first invalidates the other holders, one message per cycle, lowest processor number first. A miss to an owned block first recalls the line from its owner. The engine then waits for that owner's write-back before it updates memory and replies. The memory array behind the directory is a small behavioural RAM holding one word per block.

Top module: `hd_directory`

## Requirements
- R1: After reset every block has no cached copy and an empty presence vector, the word of block a holds the value a, `out_valid` is low and `req_ready` is high.
- R2: Request kinds are 0 = read miss, 1 = write miss and 2 = write-back. Response kinds are 0 = invalidate, 1 = fetch, 2 = fetch-and-invalidate and 3 = data reply. A read miss to an uncached block is answered with a data reply carrying the stored word to the requester, and the block becomes shared with the requester as its only holder.
- R3: A read miss to a shared block adds the requester to the holders and is answered with a data reply carrying the stored word.
- R4: A write miss to an uncached block is answered with a data reply, and the block becomes owned by the requester.
- R5: A write miss to a shared block first sends one invalidate to each holder other than the requester, one per accepted message, in ascending processor order. It then sends the data reply, and the requester becomes the only owner.
- R6: A read miss to an owned block sends a fetch to the owner and waits for the owner's write-back. It stores the written-back word, replies to the requester with that word, and leaves the block shared by the former owner and the requester.
- R7: A write miss to an owned block sends a fetch-and-invalidate to the owner. After the owner's write-back it stores the word, replies with it, and makes the requester the new owner.
- R8: A write-back from the owner of an owned block stores its word, leaves the block uncached and produces no response message.
- R9: While a recall is outstanding, `req_ready` stays low for every request other than a write-back from the recalled owner for the recalled block.
- R10: A write-back for a block that is not owned, or from a processor that is not its owner, is accepted and discarded: no message, and no change to state or memory.
- R11: While `out_valid` is high and `out_ready` is low, the response fields are held unchanged.
- R12: A write miss to a shared block whose only holder is the requester sends no invalidate and replies at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_kind | input | 2 | Request kind (0 read miss, 1 write miss, 2 write-back) |
| req_proc | input | PID_W | Sending processor number |
| req_addr | input | ADDR_W | Block number |
| req_data | input | DATA_W | Word carried by a write-back |
| out_valid | output | 1 | Response message present |
| out_ready | input | 1 | Interconnect takes the response this cycle |
| out_kind | output | 2 | Response kind (0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply) |
| out_dest | output | PID_W | Destination processor number |
| out_addr | output | ADDR_W | Block number the message concerns |
| out_data | output | DATA_W | Word carried by a data reply |

## Verification
The bench builds the engine with four processors, eight blocks and 16-bit words. With four processors a single block can gather three holders, so one write miss must issue a run of invalidates that skips the requester. Eight blocks keep the reset contents of every word easy to predict, including the highest block number. The 16-bit words let the written-back values differ plainly from the reset values, so a reply shows whether memory was updated or an ignored write-back leaked through.

// File: rtl/hd_pkg.sv
package hd_pkg;

    typedef enum logic [1:0] {
        BLK_NONE  = 2'd0,
        BLK_SHARE = 2'd1,
        BLK_OWNED = 2'd2
    } blk_state_e;

    typedef enum logic [1:0] {
        REQ_RDMISS = 2'd0,
        REQ_WRMISS = 2'd1,
        REQ_WRBACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_INVAL    = 2'd0,
        MSG_FETCH    = 2'd1,
        MSG_FETCHINV = 2'd2,
        MSG_REPLY    = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_INVAL = 3'd1,
        PH_FETCH = 3'd2,
        PH_WAIT  = 3'd3,
        PH_REPLY = 3'd4
    } phase_e;

endpackage

// File: rtl/hd_first_set.sv
module hd_first_set #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     onehot
);

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
        onehot = (|vec) ? (W'(1) << idx) : '0;
    end

endmodule

// File: rtl/hd_dir_table.sv
module hd_dir_table
    import hd_pkg::*;
#(
    parameter int NPROC  = 8,
    parameter int NBLK   = 64,
    parameter int DATA_W = 32,
    localparam int ADDR_W = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output blk_state_e        rd_state,
    output logic [NPROC-1:0]  rd_sharers,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  blk_state_e        wr_state,
    input  logic [NPROC-1:0]  wr_sharers,
    input  logic              wr_data_en,
    input  logic [DATA_W-1:0] wr_data
);

    blk_state_e        state_q   [NBLK];
    logic [NPROC-1:0]  sharers_q [NBLK];
    logic [DATA_W-1:0] word_q    [NBLK];

    for (genvar gi = 0; gi < NBLK; gi++) begin : g_entry
        logic hit;
        assign hit = we && (wr_addr == ADDR_W'(gi));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[gi]   <= BLK_NONE;
                sharers_q[gi] <= '0;
                word_q[gi]    <= DATA_W'(gi);
            end else if (hit) begin
                state_q[gi]   <= wr_state;
                sharers_q[gi] <= wr_sharers;
                if (wr_data_en) begin
                    word_q[gi] <= wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_state   = state_q[rd_addr];
        rd_sharers = sharers_q[rd_addr];
        rd_data    = word_q[rd_addr];
    end

endmodule

// File: rtl/hd_directory.sv
module hd_directory
    import hd_pkg::*;
#(
    parameter int NPROC  = 8,
    parameter int NBLK   = 64,
    parameter int DATA_W = 32,
    localparam int PID_W  = $clog2(NPROC),
    localparam int ADDR_W = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [PID_W-1:0]  req_proc,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [PID_W-1:0]  out_dest,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [PID_W-1:0]  req_p;
        logic              is_write;
        logic [NPROC-1:0]  pend;
        logic [PID_W-1:0]  owner;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] rd_addr;
    blk_state_e        rd_state;
    logic [NPROC-1:0]  rd_sharers;
    logic [DATA_W-1:0] rd_data;
    logic              we;
    blk_state_e        wr_state;
    logic [NPROC-1:0]  wr_sharers;
    logic              wr_data_en;
    logic [DATA_W-1:0] wr_data;

    logic [PID_W-1:0]  own_idx;
    logic [NPROC-1:0]  own_hot;
    logic [PID_W-1:0]  pend_idx;
    logic [NPROC-1:0]  pend_hot;

    hd_dir_table #(
        .NPROC (NPROC),
        .NBLK  (NBLK),
        .DATA_W(DATA_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .rd_state  (rd_state),
        .rd_sharers(rd_sharers),
        .rd_data   (rd_data),
        .we        (we),
        .wr_addr   (ctl_d.addr),
        .wr_state  (wr_state),
        .wr_sharers(wr_sharers),
        .wr_data_en(wr_data_en),
        .wr_data   (wr_data)
    );

    hd_first_set #(.W(NPROC)) owner_scan_i (
        .vec   (rd_sharers),
        .idx   (own_idx),
        .onehot(own_hot)
    );

    hd_first_set #(.W(NPROC)) pend_scan_i (
        .vec   (ctl_q.pend),
        .idx   (pend_idx),
        .onehot(pend_hot)
    );

    logic [NPROC-1:0] req_bit;
    logic [NPROC-1:0] others;
    logic             wb_match;

    always_comb begin
        ctl_d      = ctl_q;
        we         = 1'b0;
        wr_state   = BLK_NONE;
        wr_sharers = '0;
        wr_data_en = 1'b0;
        wr_data    = req_data;
        req_ready  = 1'b0;
        out_valid  = 1'b0;
        out_kind   = MSG_REPLY;
        out_dest   = ctl_q.req_p;
        out_addr   = ctl_q.addr;
        out_data   = '0;

        req_bit  = NPROC'(1) << req_proc;
        others   = rd_sharers & ~req_bit;
        wb_match = (req_kind == REQ_WRBACK) && (req_addr == ctl_q.addr)
                   && (req_proc == ctl_q.owner);
        rd_addr  = (ctl_q.phase == PH_IDLE) ? req_addr : ctl_q.addr;

        case (ctl_q.phase)
            PH_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    ctl_d.addr     = req_addr;
                    ctl_d.req_p    = req_proc;
                    ctl_d.is_write = (req_kind == REQ_WRMISS);
                    ctl_d.owner    = own_idx;
                    ctl_d.data     = rd_data;
                    ctl_d.pend     = '0;
                    case (req_kind)
                        REQ_RDMISS: begin
                            if (rd_state == BLK_OWNED) begin
                                ctl_d.phase = PH_FETCH;
                            end else begin
                                we          = 1'b1;
                                wr_state    = BLK_SHARE;
                                wr_sharers  = rd_sharers | req_bit;
                                ctl_d.phase = PH_REPLY;
                            end
                        end
                        REQ_WRMISS: begin
                            if (rd_state == BLK_OWNED) begin
                                ctl_d.phase = PH_FETCH;
                            end else if (others == '0) begin
                                we          = 1'b1;
                                wr_state    = BLK_OWNED;
                                wr_sharers  = req_bit;
                                ctl_d.phase = PH_REPLY;
                            end else begin
                                ctl_d.pend  = others;
                                ctl_d.phase = PH_INVAL;
                            end
                        end
                        REQ_WRBACK: begin
                            if (rd_state == BLK_OWNED && own_hot == req_bit) begin
                                we         = 1'b1;
                                wr_state   = BLK_NONE;
                                wr_sharers = '0;
                                wr_data_en = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            PH_INVAL: begin
                out_valid = 1'b1;
                out_kind  = MSG_INVAL;
                out_dest  = pend_idx;
                if (out_ready) begin
                    ctl_d.pend = ctl_q.pend & ~pend_hot;
                    if (ctl_d.pend == '0) begin
                        we          = 1'b1;
                        wr_state    = BLK_OWNED;
                        wr_sharers  = NPROC'(1) << ctl_q.req_p;
                        ctl_d.phase = PH_REPLY;
                    end
                end
            end
            PH_FETCH: begin
                out_valid = 1'b1;
                out_kind  = ctl_q.is_write ? MSG_FETCHINV : MSG_FETCH;
                out_dest  = ctl_q.owner;
                if (out_ready) begin
                    ctl_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                req_ready = wb_match;
                if (req_valid && wb_match) begin
                    we          = 1'b1;
                    wr_data_en  = 1'b1;
                    ctl_d.data  = req_data;
                    if (ctl_q.is_write) begin
                        wr_state   = BLK_OWNED;
                        wr_sharers = NPROC'(1) << ctl_q.req_p;
                    end else begin
                        wr_state   = BLK_SHARE;
                        wr_sharers = (NPROC'(1) << ctl_q.req_p)
                                   | (NPROC'(1) << ctl_q.owner);
                    end
                    ctl_d.phase = PH_REPLY;
                end
            end
            PH_REPLY: begin
                out_valid = 1'b1;
                out_kind  = MSG_REPLY;
                out_dest  = ctl_q.req_p;
                out_data  = ctl_q.data;
                if (out_ready) begin
                    ctl_d.phase = PH_IDLE;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/hd_directory_chk.sv
module hd_directory_chk #(
    parameter int NPROC  = 8,
    parameter int NBLK   = 64,
    parameter int DATA_W = 32,
    localparam int PID_W  = $clog2(NPROC),
    localparam int ADDR_W = $clog2(NBLK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic [PID_W-1:0]  req_proc,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_kind,
    input logic [PID_W-1:0]  out_dest,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data
);

    logic             recall_q;
    logic             busy_q;
    logic             inv_seen_q;
    logic [PID_W-1:0] inv_last_q;
    logic [PID_W-1:0] asker_q;

    wire req_fire = req_valid && req_ready;
    wire out_fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recall_q   <= 1'b0;
            busy_q     <= 1'b0;
            inv_seen_q <= 1'b0;
            inv_last_q <= '0;
            asker_q    <= '0;
        end else begin
            if (out_fire && (out_kind == 2'd1 || out_kind == 2'd2)) recall_q <= 1'b1;
            if (req_fire && req_kind == 2'd2) recall_q <= 1'b0;
            if (req_fire && req_kind != 2'd2 && !busy_q) begin
                busy_q  <= 1'b1;
                asker_q <= req_proc;
            end
            if (out_fire && out_kind == 2'd3) begin
                busy_q     <= 1'b0;
                inv_seen_q <= 1'b0;
            end
            if (out_fire && out_kind == 2'd0) begin
                inv_seen_q <= 1'b1;
                inv_last_q <= out_dest;
            end
        end
    end

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_dest)
                                    && $stable(out_addr) && $stable(out_data));

    assert_recall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recall_q && req_kind != 2'd2 |-> !req_ready);

    assert_inval_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire && out_kind == 2'd0 && inv_seen_q |-> out_dest > inv_last_q);

    assert_inval_skips_asker_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 2'd0 |-> out_dest != asker_q);

    assert_reply_to_asker_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 2'd3 |-> out_dest == asker_q);

    assert_silent_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !out_valid);

endmodule

bind hd_directory hd_directory_chk #(
    .NPROC (NPROC),
    .NBLK  (NBLK),
    .DATA_W(DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_kind (req_kind),
    .req_proc (req_proc),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_kind (out_kind),
    .out_dest (out_dest),
    .out_addr (out_addr),
    .out_data (out_data)
);

// File: tb/hd_directory_tb_top.sv
module hd_directory_tb_top;

    localparam int NPROC  = 4;
    localparam int NBLK   = 8;
    localparam int DATA_W = 16;
    localparam int PID_W  = $clog2(NPROC);
    localparam int ADDR_W = $clog2(NBLK);

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
    localparam logic [1:0] M_INV = 2'd0, M_FET = 2'd1, M_FIN = 2'd2, M_REP = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [PID_W-1:0]  req_proc = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [1:0]        out_kind;
    logic [PID_W-1:0]  out_dest;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;

    always #10 clk = ~clk;

    hd_directory #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_proc(req_proc), .req_addr(req_addr), .req_data(req_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dest(out_dest), .out_addr(out_addr), .out_data(out_data)
    );

    typedef struct {
        logic [1:0] kind;
        int         dest;
        int         addr;
        int         data;
        bit         has_data;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   stall_en = 1'b0;
    bit   finished = 1'b0;
    bit   held_q = 1'b0;
    logic [1:0]        h_kind;
    logic [PID_W-1:0]  h_dest;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic expect_msg(input logic [1:0] k, input int d, input int a,
                              input int v, input bit hd, input string tag);
        exp_t e;
        e.kind = k; e.dest = d; e.addr = a; e.data = v; e.has_data = hd; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic send(input logic [1:0] k, input int p, input int a, input int v);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_proc  = PID_W'(p);
        req_addr  = ADDR_W'(a);
        req_data  = DATA_W'(v);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic settle(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, tag, "pending expected messages", exp_q.size(), 0);
        check(out_valid == 1'b0, tag, "out_valid after quiet", int'(out_valid), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        out_ready = stall_en ? (cyc % 3 == 0) : 1'b1;
        if (rst_n && held_q && stall_en) begin
            check(out_valid && out_kind == h_kind && out_dest == h_dest &&
                  out_addr == h_addr && out_data == h_data,
                  "R11", "held response changed", int'(out_dest), int'(h_dest));
        end
        held_q = rst_n && out_valid && !out_ready;
        h_kind = out_kind; h_dest = out_dest; h_addr = out_addr; h_data = out_data;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected message kind", int'(out_kind), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_kind == e.kind, e.tag, "kind", int'(out_kind), int'(e.kind));
                check(int'(out_dest) == e.dest, e.tag, "dest", int'(out_dest), e.dest);
                check(int'(out_addr) == e.addr, e.tag, "addr", int'(out_addr), e.addr);
                if (e.has_data)
                    check(int'(out_data) == e.data, e.tag, "data", int'(out_data), e.data);
            end
        end
        if (cyc > 20000) begin
            check(1'b0, "watchdog", "run did not end, cycle", cyc, 20000);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

        // R2: read miss to uncached block 3, reset word = 3
        expect_msg(M_REP, 1, 3, 3, 1, "R2");
        send(K_RD, 1, 3, 0);
        settle("R2");
        // R3: further readers join
        expect_msg(M_REP, 0, 3, 3, 1, "R3");
        send(K_RD, 0, 3, 0);
        expect_msg(M_REP, 3, 3, 3, 1, "R3");
        send(K_RD, 3, 3, 0);
        settle("R3");

        // R5: write miss by holder 1 with holders {0,1,3}, under output stalls (R11)
        stall_en = 1'b1;
        expect_msg(M_INV, 0, 3, 0, 0, "R5");
        expect_msg(M_INV, 3, 3, 0, 0, "R5");
        expect_msg(M_REP, 1, 3, 3, 1, "R5");
        send(K_WR, 1, 3, 0);
        settle("R5");
        stall_en = 1'b0;

        // R6: read miss to owned block -> fetch to owner 1
        expect_msg(M_FET, 1, 3, 0, 0, "R6");
        send(K_RD, 2, 3, 0);
        settle("R6");
        // R9: other requests are held off while the recall is open
        @(negedge clk);
        req_valid = 1'b1; req_kind = K_RD; req_proc = 2'd0; req_addr = 3'd5;
        repeat (3) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R9", "ready for other read", int'(req_ready), 0);
        end
        req_kind = K_WB; req_proc = 2'd3; req_addr = 3'd3;
        @(negedge clk);
        check(req_ready == 1'b0, "R9", "ready for wrong writer", int'(req_ready), 0);
        req_valid = 1'b0;
        expect_msg(M_REP, 2, 3, 16'h00AB, 1, "R6");
        send(K_WB, 1, 3, 16'h00AB);
        settle("R6");

        // R5: holders {1,2}, requester 2 skipped
        expect_msg(M_INV, 1, 3, 0, 0, "R5");
        expect_msg(M_REP, 2, 3, 16'h00AB, 1, "R5");
        send(K_WR, 2, 3, 0);
        settle("R5");

        // R7: write miss to owned block -> fetch-and-invalidate
        expect_msg(M_FIN, 2, 3, 0, 0, "R7");
        send(K_WR, 0, 3, 0);
        settle("R7");
        expect_msg(M_REP, 0, 3, 16'h00CD, 1, "R7");
        send(K_WB, 2, 3, 16'h00CD);
        settle("R7");

        // R10: stray write-backs are dropped
        send(K_WB, 3, 3, 16'h0099);
        send(K_WB, 1, 6, 16'h0055);
        settle("R10");

        // R8: owner write-back, silent, then memory shows the word without a recall
        send(K_WB, 0, 3, 16'h0077);
        settle("R8");
        expect_msg(M_REP, 2, 3, 16'h0077, 1, "R8");
        send(K_RD, 2, 3, 0);
        settle("R8");

        // R12: sole holder upgrades with no invalidate
        expect_msg(M_REP, 2, 3, 16'h0077, 1, "R12");
        send(K_WR, 2, 3, 0);
        settle("R12");

        // R4 and R10: block 6 kept its reset word
        expect_msg(M_REP, 1, 6, 6, 1, "R4");
        send(K_WR, 1, 6, 0);
        settle("R4");
        expect_msg(M_FET, 1, 6, 0, 0, "R4");
        send(K_RD, 3, 6, 0);
        expect_msg(M_REP, 3, 6, 16'h0123, 1, "R6");
        send(K_WB, 1, 6, 16'h0123);
        settle("R6");

        // R1: highest block holds its reset word
        expect_msg(M_REP, 0, 7, 7, 1, "R1");
        send(K_RD, 0, 7, 0);
        settle("R1");

        summary();
    end

endmodule